// File: doc/BRIEF.md
# Printer Data Strobe Generator

This block drives the data and handshake side of a parallel printer port. A host writes a byte through a single shared byte address; the byte is latched onto the printer data pins and, in automatic mode, a strobe pulse follows so the printer takes it. Reading the same address returns a status byte assembled from the printer's busy, paper-empty, select, fault and acknowledge lines. These lines pass through a two-stage synchronizer before they are sampled.

A second address holds a four-bit control register. This register chooses between automatic and manual strobe, selects one of two automatic pulse widths (6.4 us or 1.6 us), drives the strobe directly in manual mode, and drives the input-prime output. Pulse widths are counted in clock cycles from a clock-frequency parameter and rounded up. The data byte is held on the pins for one clock before the pulse, for the whole pulse, and for one clock after it. A data write that arrives during an automatic transfer is stalled through `wr_stall` until the transfer ends. The host keeps the write request asserted until the block accepts it.

Top module: `prn_strobe_gen`

## Requirements
- R1: A write with `bus_addr`=0 loads `bus_wdata` onto `prn_data` from the clock edge that accepts it. The reset value of `prn_data` is 0x00.
- R2: A read with `bus_addr`=0 returns {ack, fault, select, paper_empty, busy, 3'b000}, bits 7 down to 3. Each line appears there two clock edges after it changes at the pins.
- R3: In automatic mode (control bit 0 clear), each accepted data write raises `prn_strobe` one clock after the new byte appears on `prn_data`.
- R4: The automatic pulse lasts ceil(6400 ns x CLK_HZ / 1e9) cycles with control bit 1 clear, and ceil(1600 ns x CLK_HZ / 1e9) cycles with control bit 1 set. This is 320 and 80 cycles at 50 MHz.
- R5: `prn_data` stays unchanged while the automatic strobe is high and for one cycle after it falls.
- R6: `wr_stall` is high from the accepting edge until one cycle after the strobe falls. A data write during that time does not change `prn_data` or the pulse. It is accepted on the first edge after `wr_stall` drops, and it then produces its own pulse.
- R7: In manual mode (control bit 0 set), `prn_strobe` equals control bit 2. Data writes update `prn_data` without a pulse and without raising `wr_stall`.
- R8: `prn_prime` equals control bit 3 from the edge that writes it.
- R9: A read with `bus_addr`=1 returns {4'b0000, control[3:0]}. Control writes are never stalled.
- R10: After reset, `prn_strobe`, `prn_prime` and `wr_stall` are low and the control register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Write request valid |
| bus_wr | input | 1 | Write when high |
| bus_addr | input | 1 | 0 = data/status, 1 = control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| wr_stall | output | 1 | Data write held off; automatic transfer in progress |
| prn_data | output | 8 | Printer data pins |
| prn_strobe | output | 1 | Printer strobe, active high |
| prn_prime | output | 1 | Printer input-prime, active high |
| prn_busy | input | 1 | Printer busy line |
| prn_pe | input | 1 | Printer paper-empty line |
| prn_select | input | 1 | Printer select line |
| prn_fault | input | 1 | Printer fault line |
| prn_ack | input | 1 | Printer acknowledge line |

## Verification
The hardest situation to reach is a second data write that lands while an automatic pulse is running. The stall must then hold it without disturbing the pins, and a fresh pulse must follow once the stall clears. The stimulus starts a pulse and, in a parallel thread, holds a second write on the bus while the first pulse is measured cycle by cycle. Random bytes with random width selection exercise both pulse lengths. Random status patterns are checked against a bench-computed bit layout, and the bench also checks the synchronizer's two-edge latency.

// File: rtl/prn_pkg.sv
package prn_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_PULSE, ST_HOLD} strobe_st_e;

  // cycles needed to cover ns at hz, rounded up
  function automatic int unsigned ns_to_cycles(longint unsigned ns, longint unsigned hz);
    longint unsigned prod;
    prod = ns * hz + 64'd999_999_999;
    return int'(prod / 64'd1_000_000_000);
  endfunction
endpackage

// File: rtl/prn_in_sync.sv
module prn_in_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/prn_strobe_fsm.sv
module prn_strobe_fsm
  import prn_pkg::*;
#(
  parameter longint unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned     SLOW_NS = 6400,
  parameter int unsigned     FAST_NS = 1600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       data_wr,
  input  logic       auto_mode,
  input  logic       fast_sel,
  input  logic [7:0] wdata,
  output logic [7:0] data_o,
  output logic       pulse_active,
  output logic       busy
);
  localparam int unsigned SLOW_CYC = ns_to_cycles(SLOW_NS, CLK_HZ);
  localparam int unsigned FAST_CYC = ns_to_cycles(FAST_NS, CLK_HZ);
  localparam int unsigned MAX_CYC  = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
  localparam int          CW       = $clog2(MAX_CYC + 1);

  strobe_st_e    st_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    data_q;
  logic          start_auto;
  logic          width_fast_q;

  assign start_auto = data_wr && auto_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_wr) begin
      data_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      cnt_q        <= '0;
      width_fast_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE:  if (start_auto) st_q <= ST_SETUP;
        ST_SETUP: begin
          st_q         <= ST_PULSE;
          width_fast_q <= fast_sel;
          cnt_q        <= fast_sel ? CW'(FAST_CYC - 1) : CW'(SLOW_CYC - 1);
        end
        ST_PULSE: begin
          if (cnt_q == '0) st_q <= ST_HOLD;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign data_o       = data_q;
  assign pulse_active = (st_q == ST_PULSE);
  assign busy         = (st_q != ST_IDLE);

  // independent pulse-length checker
  logic [CW:0] chk_len_q;
  logic        chk_fast_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_len_q  <= '0;
      chk_fast_q <= 1'b0;
    end else if (pulse_active) begin
      chk_len_q  <= chk_len_q + 1'b1;
    end else begin
      chk_len_q  <= '0;
      chk_fast_q <= fast_sel;
    end
  end

  assert_setup_before_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_active) |-> $stable(data_q));
  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_active || (busy && !pulse_active && $past(pulse_active))) |-> $stable(data_q));
  assert_pulse_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_active) |->
      (chk_len_q == (chk_fast_q ? (CW+1)'(FAST_CYC) : (CW+1)'(SLOW_CYC))));
  assert_no_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !data_wr);
  wire unused_ok = width_fast_q;
endmodule

// File: rtl/prn_strobe_gen.sv
module prn_strobe_gen #(
  parameter longint unsigned CLK_HZ      = 50_000_000,
  parameter int              SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       wr_stall,
  output logic [7:0] prn_data,
  output logic       prn_strobe,
  output logic       prn_prime,
  input  logic       prn_busy,
  input  logic       prn_pe,
  input  logic       prn_select,
  input  logic       prn_fault,
  input  logic       prn_ack
);
  localparam int STAT_W = 5;

  logic [3:0]        ctrl_q;
  logic [STAT_W-1:0] stat_sync;
  logic              fsm_busy;
  logic              pulse_active;
  logic              data_wr;
  logic              ctrl_wr;

  assign ctrl_wr  = bus_sel && bus_wr && bus_addr;
  assign data_wr  = bus_sel && bus_wr && !bus_addr && !fsm_busy;
  assign wr_stall = fsm_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= bus_wdata[3:0];
  end

  prn_in_sync #(.WIDTH(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({prn_ack, prn_fault, prn_select, prn_pe, prn_busy}),
    .sync_o  (stat_sync)
  );

  prn_strobe_fsm #(.CLK_HZ(CLK_HZ)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .data_wr      (data_wr),
    .auto_mode    (!ctrl_q[0]),
    .fast_sel     (ctrl_q[1]),
    .wdata        (bus_wdata),
    .data_o       (prn_data),
    .pulse_active (pulse_active),
    .busy         (fsm_busy)
  );

  assign prn_strobe = ctrl_q[0] ? ctrl_q[2] : pulse_active;
  assign prn_prime  = ctrl_q[3];
  assign bus_rdata  = bus_addr ? {4'b0000, ctrl_q} : {stat_sync, 3'b000};

  assert_prime_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (prn_prime == $past(bus_wdata[3])));
  assert_manual_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[0]) |=> (prn_strobe == $past(bus_wdata[2])));
  assert_status_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr |-> (bus_rdata[2:0] == 3'b000));
  assert_manual_no_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && !fsm_busy) |=> !wr_stall);
endmodule

// File: tb/prn_strobe_gen_bench.sv
module prn_strobe_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, prn_data;
  logic wr_stall, prn_strobe, prn_prime;
  logic prn_busy = 0, prn_pe = 0, prn_select = 0, prn_fault = 0, prn_ack = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prn_strobe_gen u_prn_strobe_gen (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wr_stall(wr_stall), .prn_data(prn_data), .prn_strobe(prn_strobe),
    .prn_prime(prn_prime), .prn_busy(prn_busy), .prn_pe(prn_pe),
    .prn_select(prn_select), .prn_fault(prn_fault), .prn_ack(prn_ack)
  );

  function automatic int exp_width(bit fast);
    int ns = fast ? 1600 : 6400;
    return (ns * 50 + 999) / 1000;
  endfunction

  function automatic logic [7:0] exp_status(logic [4:0] v);
    logic [7:0] s = '0;
    s[3] = v[0]; s[4] = v[1]; s[5] = v[2]; s[6] = v[3]; s[7] = v[4];
    return s;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(logic a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    while (a == 1'b0 && wr_stall) @(negedge clk);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic do_read(logic a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  // entered at the negedge after the accepting edge
  task automatic check_pulse(logic [7:0] d, bit fast);
    int w = 0, bad = 0;
    chk(prn_data == d, "R1", prn_data, d);
    chk(prn_strobe == 0 && wr_stall == 1, "R3", {prn_strobe, wr_stall}, 2'b01);
    @(negedge clk);
    while (prn_strobe && w < 1000) begin
      if (prn_data != d) bad++;
      w++;
      @(negedge clk);
    end
    chk(w == exp_width(fast), "R4", w, exp_width(fast));
    chk(bad == 0 && prn_data == d, "R5", bad, 0);
    chk(wr_stall == 1, "R6", wr_stall, 1);
    @(negedge clk);
    chk(wr_stall == 0, "R6", wr_stall, 0);
  endtask

  initial begin
    logic [7:0] rv;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(prn_strobe == 0 && prn_prime == 0 && wr_stall == 0, "R10",
        {prn_strobe, prn_prime, wr_stall}, 0);
    chk(prn_data == 8'h00, "R1", prn_data, 0);
    rst_n = 1;
    do_read(1, rv);
    chk(rv == 8'h00, "R10", rv, 0);

    // directed: slow then fast pulse
    do_write(0, 8'hA5);
    check_pulse(8'hA5, 0);
    do_write(1, 8'h02);
    do_write(0, 8'h3C);
    check_pulse(8'h3C, 1);

    // random pulses
    for (int i = 0; i < 10; i++) begin
      bit f = 1'($urandom);
      logic [7:0] d = 8'($urandom);
      do_write(1, {6'b0, f, 1'b0});
      do_write(0, d);
      check_pulse(d, f);
    end

    // R6: write while busy
    do_write(1, 8'h02);
    do_write(0, 8'h11);
    fork
      check_pulse(8'h11, 1);
      do_write(0, 8'h22);
    join
    check_pulse(8'h22, 1);

    // R9 control readback, upper bits ignored
    do_write(1, 8'hF6);
    do_read(1, rv);
    chk(rv == 8'h06, "R9", rv, 8'h06);

    // R7 manual mode
    do_write(1, 8'h01);
    chk(prn_strobe == 0, "R7", prn_strobe, 0);
    do_write(1, 8'h05);
    chk(prn_strobe == 1, "R7", prn_strobe, 1);
    do_write(0, 8'h77);
    chk(prn_data == 8'h77 && wr_stall == 0 && prn_strobe == 1, "R7",
        {prn_data, wr_stall, prn_strobe}, {8'h77, 2'b01});
    do_write(1, 8'h01);
    do_write(0, 8'h78);
    repeat (3) begin
      @(negedge clk);
      chk(prn_strobe == 0 && wr_stall == 0, "R7", {prn_strobe, wr_stall}, 0);
    end

    // R8 input prime
    do_write(1, 8'h08);
    chk(prn_prime == 1, "R8", prn_prime, 1);
    do_write(1, 8'h00);
    chk(prn_prime == 0, "R8", prn_prime, 0);

    // R2 status layout and latency
    bus_addr = 0;
    for (int i = 0; i < 12; i++) begin
      logic [4:0] v = 5'($urandom);
      {prn_ack, prn_fault, prn_select, prn_pe, prn_busy} = v;
      repeat (3) @(negedge clk);
      #1 chk(bus_rdata == exp_status(v), "R2", bus_rdata, exp_status(v));
    end
    @(negedge clk);
    {prn_ack, prn_fault, prn_select, prn_pe, prn_busy} = 5'b00000;
    repeat (3) @(negedge clk);
    prn_ack = 1;
    @(negedge clk);
    #1 chk(bus_rdata == 8'h00, "R2", bus_rdata, 0);
    @(negedge clk);
    #1 chk(bus_rdata == 8'h80, "R2", bus_rdata, 8'h80);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule